// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable, scaled-down model of a pipelined synchronous static memory. Its shared data bus can carry a read in one cycle and a write in the next with no idle cycle between them. Every control and address input is captured on the rising clock edge. Write data is delayed through the pipeline so that it occupies the same bus slot that read data of the same age would occupy. This alignment is what removes the turnaround gap.

A loaded base address can be followed by advance cycles. A two-bit counter then steps through the aligned group of four words, in either linear or interleaved order. A clock enable freezes the whole pipeline. A sleep input shuts out new accesses while the stored contents are kept. The default array holds 256 words of 18 bits, arranged as two 9-bit byte lanes.

Top module: `zt_sram`

## Requirements
- R1: A new access starts at an enabled edge only when burst_adv=0, ce_a_n=0, ce_b=1 and ce_c_n=0. At that edge we_n=0 selects a write and we_n=1 a read. If burst_adv=0 and any chip select is inactive, no access starts.
- R2: Read data for an address captured at enabled edge k is driven on dq from just after enabled edge k+1 until enabled edge k+2.
- R3: Write data for an address captured at enabled edge k is taken from dq at enabled edge k+2.
- R4: With burst_adv=1 and a burst in progress, each enabled edge performs one more access of the same direction. The counter steps by one, modulo four, so the fifth access returns to the base word.
- R5: With seq_mode=1 (linear) the burst word is the base address with its two low bits replaced by (base low bits + count) mod 4.
- R6: With seq_mode=0 (interleaved) the two low bits are base low bits XOR count. The mode is taken at the load edge.
- R7: During a write, byte lane i (dq bits 9i+8..9i) is updated only if bwe_n[i]=0. Bit 0 is the low lane.
- R8: While cke_n=1, no state changes: the bus stays as it was, including read data already being driven and any pending write.
- R9: The memory drives dq only in read slots. In write slots and idle slots it leaves dq released, and it is released after reset.
- R10: Reads and writes may alternate on every consecutive enabled edge with no dead cycles, and each returns correct data.
- R11: A read whose address matches the write in the slot just before it returns that write's data, merged byte by byte with the stored word.
- R12: An access at enabled edge k is ignored if sleep was 1 at enabled edge k-2. Entering sleep ends any burst, and stored data is unchanged across sleep.
- R13: A deselect cycle (burst_adv=0, not selected) ends a burst, so later advance cycles perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, low active; high stalls the block |
| ce_a_n | input | 1 | Chip select, low active |
| ce_b | input | 1 | Chip select, high active |
| ce_c_n | input | 1 | Chip select, low active |
| we_n | input | 1 | 0 = write, 1 = read, sampled on load cycles |
| bwe_n | input | NB | Per-lane write enables, low active |
| burst_adv | input | 1 | 0 = load new address, 1 = advance burst |
| seq_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Low-power request |
| addr | input | AW | Word address |
| dq | inout | NB*BW | Bidirectional data bus |

## Verification
Most internal faults in this block reach dq within two enabled edges. A stray or missing slot registration either turns a read into silence or leaves the bus released where data was expected. A wrong burst count or order shows up as a word from the wrong position within the four-word group on the very next advance. Faulty forwarding or lane masking stays hidden in the array until the word is read. The bench therefore reads every written location back, often in the immediately following slot. A stall that leaks state is caught by re-checking the held read value on every stalled cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int CNT_W = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } order_e;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // low address bits of the burst word for a given count
    function automatic cnt_t burst_low(cnt_t base, cnt_t cnt, order_e ord);
        cnt_t r;
        if (ord == ORD_LINEAR) r = cnt_t'(base + cnt);
        else                   r = base ^ cnt;
        return r;
    endfunction

endpackage

// File: rtl/zt_sleep_sync.sv
module zt_sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sleep_req,
    output logic asleep
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)     sh <= '0;
                else if (en) sh <= sleep_req;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)     sh <= '0;
                else if (en) sh <= {sh[STAGES-2:0], sleep_req};
            end
        end
    endgenerate

    assign asleep = sh[STAGES-1];

    // R12: a request held low for STAGES enabled edges always clears the sleep state
    p_wake_follows_r12: assert property (@(posedge clk) disable iff (rst)
        (en && !sleep_req && sh == '0) |=> !asleep);

endmodule

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
    import zt_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          asleep,
    input  logic          sel,
    input  logic          we_n,
    input  logic [NB-1:0] bwe_n,
    input  logic          adv,
    input  logic          mode,
    input  logic [AW-1:0] addr,
    output logic          req_valid,
    op_e                  req_op,
    output logic [AW-1:0] req_addr,
    output logic [NB-1:0] req_mask
);
    logic          active;
    op_e           op_q;
    order_e        ord_q;
    logic [AW-1:0] base_q;
    cnt_t          cnt_q;
    cnt_t          cnt_nxt;

    assign cnt_nxt = cnt_t'(cnt_q + 1'b1);

    always_comb begin
        req_valid = 1'b0;
        req_op    = OP_READ;
        req_addr  = addr;
        req_mask  = ~bwe_n;
        if (!asleep) begin
            if (!adv) begin
                if (sel) begin
                    req_valid = 1'b1;
                    req_op    = we_n ? OP_READ : OP_WRITE;
                end
            end else if (active) begin
                req_valid = 1'b1;
                req_op    = op_q;
                req_addr  = {base_q[AW-1:CNT_W], burst_low(base_q[CNT_W-1:0], cnt_nxt, ord_q)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            op_q   <= OP_READ;
            ord_q  <= ORD_INTERLEAVE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (asleep) begin
                active <= 1'b0;
            end else if (!adv) begin
                active <= sel;
                if (sel) begin
                    op_q   <= we_n ? OP_READ : OP_WRITE;
                    ord_q  <= order_e'(mode);
                    base_q <= addr;
                    cnt_q  <= '0;
                end
            end else if (active) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // R4: every burst word stays inside the aligned group of its base
    p_group_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && adv) |-> (req_addr[AW-1:CNT_W] == base_q[AW-1:CNT_W]));

    // R4: an accepted advance moves the counter by exactly one
    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (en && adv && req_valid) |=> (cnt_q == cnt_t'($past(cnt_q) + 1'b1)));

    // R13: a deselect edge leaves no burst running
    p_desel_ends_r13: assert property (@(posedge clk) disable iff (rst)
        (en && !adv && !sel) |=> !active);

endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*BW-1:0] rd_word,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_mask,
    input  logic [NB*BW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] mem [DEPTH];
        logic [BW-1:0] lane_out;
        logic          bypass;

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) mem[wr_addr] <= wr_data[b*BW +: BW];
        end

        // R11: lane written in this very slot is taken from the bus
        assign bypass   = wr_en && wr_mask[b] && (wr_addr == rd_addr);
        assign lane_out = bypass ? wr_data[b*BW +: BW] : mem[rd_addr];
        assign rd_word[b*BW +: BW] = lane_out;
    end

    // R11: a full-word write to the read address is seen unchanged
    p_bypass_full_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (&wr_mask) && wr_addr == rd_addr) |-> (rd_word == wr_data));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW           = 8,
    parameter int NB           = 2,
    parameter int BW           = 9,
    parameter int SLEEP_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_n,
    input  logic             ce_a_n,
    input  logic             ce_b,
    input  logic             ce_c_n,
    input  logic             we_n,
    input  logic [NB-1:0]    bwe_n,
    input  logic             burst_adv,
    input  logic             seq_mode,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    inout  wire  [NB*BW-1:0] dq
);
    localparam int DW = NB * BW;

    typedef struct packed {
        logic          valid;
        op_e           op;
        logic [AW-1:0] addr;
        logic [NB-1:0] mask;
    } slot_t;

    logic          en;
    logic          sel;
    logic          asleep;
    logic          req_valid;
    op_e           req_op;
    logic [AW-1:0] req_addr;
    logic [NB-1:0] req_mask;
    slot_t         s1;
    slot_t         s2;
    logic          oe_q;
    logic [DW-1:0] dout_q;
    logic [DW-1:0] rd_word;
    logic          wr_en;

    assign en  = !cke_n;
    assign sel = !ce_a_n && ce_b && !ce_c_n;

    zt_sleep_sync #(.STAGES(SLEEP_STAGES)) u_sleep (
        .clk(clk), .rst(rst), .en(en), .sleep_req(sleep), .asleep(asleep)
    );

    zt_burst_ctl #(.AW(AW), .NB(NB)) u_burst (
        .clk(clk), .rst(rst), .en(en), .asleep(asleep), .sel(sel),
        .we_n(we_n), .bwe_n(bwe_n), .adv(burst_adv), .mode(seq_mode),
        .addr(addr), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_mask(req_mask)
    );

    assign wr_en = en && s2.valid && (s2.op == OP_WRITE);

    zt_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk(clk), .rst(rst), .rd_addr(s1.addr), .rd_word(rd_word),
        .wr_en(wr_en), .wr_addr(s2.addr), .wr_mask(s2.mask), .wr_data(dq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '0;
            s2     <= '0;
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else if (en) begin
            s1.valid <= req_valid;
            s1.op    <= req_op;
            s1.addr  <= req_addr;
            s1.mask  <= req_mask;
            s2       <= s1;
            oe_q     <= s1.valid && (s1.op == OP_READ);
            if (s1.valid && s1.op == OP_READ) dout_q <= rd_word;
        end
    end

    assign dq = oe_q ? dout_q : {DW{1'bz}};

    // R9: the memory drives only while the slot owner is a read
    p_drive_read_slot_r9: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (s2.valid && s2.op == OP_READ));

    // R1: an unselected load edge registers no access
    p_desel_no_access_r1: assert property (@(posedge clk) disable iff (rst)
        (en && !burst_adv && !sel) |=> !s1.valid);

    // R12: while asleep nothing enters the pipeline
    p_sleep_blocks_r12: assert property (@(posedge clk) disable iff (rst)
        (en && asleep) |=> !s1.valid);

    // R8: a stalled edge changes no pipeline or output state
    p_stall_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(s1) && $stable(s2) && $stable(oe_q) && $stable(dout_q)));

endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;
    localparam int AW = 8;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke_n = 1'b0;
    logic          ce_a_n = 1'b1;
    logic          ce_b = 1'b0;
    logic          ce_c_n = 1'b1;
    logic          we_n = 1'b1;
    logic [NB-1:0] bwe_n = '1;
    logic          burst_adv = 1'b0;
    logic          seq_mode = 1'b1;
    logic          sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    wire  [DW-1:0] dq;
    logic [DW-1:0] tb_dq = '0;
    logic          tb_oe = 1'b0;

    assign dq = tb_oe ? tb_dq : {DW{1'bz}};

    always #4 clk = ~clk;

    zt_sram #(.AW(AW), .NB(NB), .BW(BW)) i_zt_sram (
        .clk(clk), .rst(rst), .cke_n(cke_n), .ce_a_n(ce_a_n), .ce_b(ce_b),
        .ce_c_n(ce_c_n), .we_n(we_n), .bwe_n(bwe_n), .burst_adv(burst_adv),
        .seq_mode(seq_mode), .sleep(sleep), .addr(addr), .dq(dq)
    );

    typedef struct {
        bit            none;
        bit            wr;
        logic [AW-1:0] a;
        logic [NB-1:0] m;
        logic [DW-1:0] d;
        string         req;
    } item_t;

    item_t         sb[$];
    item_t         cur;
    bit            have_cur = 0;
    logic [DW-1:0] model [DEPTH];
    int            total = 0;
    int            bad = 0;

    // bench-side burst and sleep bookkeeping, from the requirements
    bit            b_active = 0;
    bit            b_wr = 0;
    bit            b_lin = 0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;
    bit            slp1 = 0;
    bit            slp2 = 0;
    bit            slp_lvl = 0;
    bit            ord_lin = 1;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one enabled edge; s = {ce_a ok, ce_b ok, ce_c ok}
    task automatic step(input bit adv, input bit [2:0] s, input bit wr, input logic [AW-1:0] a,
                        input logic [NB-1:0] m, input logic [DW-1:0] d, input string req);
        item_t it;
        logic [1:0] low;
        @(negedge clk);
        cke_n = 1'b0; burst_adv = adv; ce_a_n = !s[2]; ce_b = s[1]; ce_c_n = !s[0];
        we_n = !wr; addr = a; bwe_n = ~m; seq_mode = ord_lin; sleep = slp_lvl;
        @(posedge clk);
        it.none = 1; it.wr = 0; it.a = '0; it.m = m; it.d = d; it.req = req;
        if (slp2) begin
            b_active = 0;
        end else if (!adv) begin
            if (&s) begin
                b_active = 1; b_base = a; b_cnt = 2'd0; b_wr = wr; b_lin = ord_lin;
                it.none = 0; it.wr = wr; it.a = a;
            end else begin
                b_active = 0;
            end
        end else if (b_active) begin
            b_cnt = b_cnt + 2'd1;
            low = b_lin ? b_base[1:0] + b_cnt : b_base[1:0] ^ b_cnt;
            it.none = 0; it.wr = b_wr; it.a = {b_base[AW-1:2], low};
        end
        slp2 = slp1; slp1 = slp_lvl;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] m, input string req);
        step(0, 3'b111, 1, a, m, d, req);
    endtask
    task automatic rd(input logic [AW-1:0] a, input string req);
        step(0, 3'b111, 0, a, '1, '0, req);
    endtask
    task automatic adv_wr(input logic [DW-1:0] d, input string req);
        step(1, 3'b000, 0, '0, '1, d, req);
    endtask
    task automatic adv_rd(input string req);
        step(1, 3'b000, 1, '0, '1, '0, req);
    endtask
    task automatic idle();
        step(0, 3'b000, 0, '0, '1, '0, "idle");
    endtask
    task automatic stall(input int n);
        @(negedge clk);
        cke_n = 1'b1;
        addr = ~addr; we_n = ~we_n; burst_adv = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    // monitor: the slot after an edge belongs to the item pushed one edge earlier
    always @(posedge clk) tb_oe <= 1'b0;

    always @(negedge clk) begin
        if (!rst && sb.size() == 2) begin
            if (have_cur && !cur.none && cur.wr) begin
                for (int b = 0; b < NB; b++)
                    if (cur.m[b]) model[cur.a][b*BW +: BW] = cur.d[b*BW +: BW];
            end
            cur = sb.pop_front();
            have_cur = 1;
        end
        if (have_cur && !cur.none) begin
            if (cur.wr) begin
                tb_dq = cur.d;
                tb_oe = 1'b1;
                #1;
                check(dq === cur.d, "R9 bus free in write slot", dq, cur.d);
            end else begin
                #1;
                check(dq === model[cur.a], cur.req, dq, model[cur.a]);
            end
        end
    end

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        // reset state: memory leaves the bus released (R9)
        @(negedge clk);
        tb_dq = 18'h2A5A5; tb_oe = 1'b1;
        #1 check(dq === 18'h2A5A5, "R9 released in reset", dq, 18'h2A5A5);
        rst = 1'b0;

        // R1, R2, R3: single writes, then reads
        wr(8'h10, 18'h11111, 2'b11, "R3");
        wr(8'h11, 18'h22222, 2'b11, "R3");
        wr(8'h20, 18'h0ABCD, 2'b11, "R3");
        wr(8'h60, 18'h06060, 2'b11, "R3");
        wr(8'h70, 18'h07070, 2'b11, "R3");
        wr(8'h71, 18'h07171, 2'b11, "R3");
        wr(8'h80, 18'h08080, 2'b11, "R3");
        rd(8'h10, "R2 read after write");
        rd(8'h11, "R2 read after write");
        // R1: one chip select inactive each time: ignored writes
        step(0, 3'b011, 1, 8'h20, 2'b11, 18'h3FFFF, "R1");
        step(0, 3'b101, 1, 8'h20, 2'b11, 18'h3FFFF, "R1");
        step(0, 3'b110, 1, 8'h20, 2'b11, 18'h3FFFF, "R1");
        rd(8'h20, "R1 deselected write ignored");

        // R10: alternate every edge
        wr(8'h30, 18'h13579, 2'b11, "R10");
        rd(8'h10, "R10 alternating read");
        wr(8'h31, 18'h2468A, 2'b11, "R10");
        rd(8'h30, "R10 alternating read");
        wr(8'h32, 18'h1F0F0, 2'b11, "R10");
        rd(8'h11, "R10 alternating read");

        // R11: read right behind a write to the same word
        wr(8'h40, 18'h1CAFE, 2'b11, "R11");
        rd(8'h40, "R11 forwarded full word");
        wr(8'h40, 18'h00155, 2'b01, "R11");
        rd(8'h40, "R11 forwarded low lane merge");

        // R7: lane masks
        wr(8'h41, 18'h3FFFF, 2'b11, "R7");
        wr(8'h41, 18'h00000, 2'b10, "R7");
        idle();
        rd(8'h41, "R7 high lane only");
        wr(8'h41, 18'h12345, 2'b00, "R7");
        idle();
        rd(8'h41, "R7 no lane written");

        // R4, R5: linear write burst from a mid-group base, then read back
        ord_lin = 1;
        wr(8'h52, 18'h05252, 2'b11, "R5");
        adv_wr(18'h05353, "R5");
        adv_wr(18'h05050, "R5");
        adv_wr(18'h05151, "R5");
        rd(8'h50, "R5 linear wrap word");
        rd(8'h53, "R5 linear second word");
        // linear read burst with a fifth advance back to base (R4)
        rd(8'h51, "R4 burst load");
        adv_rd("R5 linear read");
        adv_rd("R5 linear read");
        adv_rd("R5 linear read");
        adv_rd("R4 counter wraps to base");

        // R6: interleaved read burst
        ord_lin = 0;
        rd(8'h53, "R6 burst load");
        adv_rd("R6 interleaved read");
        adv_rd("R6 interleaved read");
        adv_rd("R6 interleaved read");
        ord_lin = 1;

        // R8: stall while read data is on the bus, and between write address and data
        rd(8'h10, "R8 read held through stall");
        idle();
        stall(3);
        idle();
        wr(8'h60, 18'h16161, 2'b11, "R8");
        stall(2);
        idle();
        rd(8'h60, "R8 write survives stall");

        // R13: deselect ends a write burst; the advance writes nothing
        wr(8'h70, 18'h17777, 2'b11, "R13");
        idle();
        adv_wr(18'h3DEAD, "R13");
        idle();
        rd(8'h71, "R13 advance after deselect ignored");
        rd(8'h70, "R13 burst word before deselect");

        // R12: sleep blocks accesses two edges later, data kept
        slp_lvl = 1;
        idle();
        idle();
        wr(8'h80, 18'h3BEEF, 2'b11, "R12");
        slp_lvl = 0;
        wr(8'h80, 18'h3BEEF, 2'b11, "R12");
        rd(8'h80, "R12 read while still asleep");
        rd(8'h80, "R12 data kept across sleep");
        wr(8'h81, 18'h18181, 2'b11, "R12");
        rd(8'h81, "R12 normal after wake");

        repeat (3) idle();
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule